// File: doc/BRIEF.md
# Watchdog Supervisor with Reset-Cause Flag

This block watches over a processor in two ways. A watchdog counts a free-running timebase tick and raises the reset output when software fails to service it within the chosen period. Independently, a low-supply comparator input forces the same reset output and a memory-access block signal for as long as the supply stays low.

Software picks the watchdog period with a 3-bit select, written through a write strobe. Seven codes give periods from 150 ms to one minute. The eighth code turns the watchdog off. A kick strobe restarts the period. A watchdog timeout produces a reset pulse of fixed length, after which counting starts again from zero.

A volatile two-bit cause flag records which source produced the most recent reset. Software reads the flag after it restarts and clears it with an explicit strobe.

Top module: `wdt_supervisor`

## Requirements
- R1: The select register holds the code written with `sel_wr_i`. Codes 0..6 give 150, 450, 1000, 5000, 10000, 20000 and 60000 ms. A period lasts ms × `TICKS_PER_MS` / `TB_DIV` ticks, with a minimum of 1. `rst_o` rises at the clock edge that samples the last tick of that period, counted from the most recent restart.
- R2: Select code 7 switches the watchdog off. With code 7, no number of ticks ever asserts `rst_o`.
- R3: `kick_i` restarts the count at zero and takes priority over a tick in the same cycle. While a watchdog reset pulse is active, `kick_i` has no effect.
- R4: A write of the period select restarts the count at zero, even when the code written is unchanged.
- R5: A watchdog reset pulse lasts exactly `PULSE_TICKS` ticks. It ends at the edge that samples the last of those ticks, and the period count then restarts from zero.
- R6: While `vlow_i` is high, `rst_o` is high in the same cycle. The watchdog count is held at zero, an active watchdog pulse is cancelled, and no watchdog pulse can start.
- R7: `mem_block_o` is high exactly while `vlow_i` is high.
- R8: `cause_o` uses 00 for none, 01 for watchdog and 10 for low supply. A watchdog pulse start writes 01. A rising `vlow_i` writes 10. Both take effect at the edge that samples the event, and the newest event overwrites the older one.
- R9: Only `flag_clr_i` sets `cause_o` to 00. The end of a reset does not clear it. If a new event and a clear arrive in the same cycle, the event is kept.
- R10: During and just after `rst_ni` low, `cause_o` is 00, the select code is 0, the count is zero, and `rst_o` follows `vlow_i` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick strobe, one clock wide |
| kick_i | input | 1 | Watchdog service strobe |
| sel_wr_i | input | 1 | Write strobe for the period select |
| sel_i | input | 3 | Period select code |
| vlow_i | input | 1 | Low-supply comparator output, already synchronous |
| flag_clr_i | input | 1 | Clears the cause flag |
| rst_o | output | 1 | Supervisor reset, active high |
| mem_block_o | output | 1 | Blocks memory reads and writes while the supply is low |
| cause_o | output | 2 | Cause of the last reset: 00 none, 01 watchdog, 10 low supply |

## Verification
Every active select code is run to timeout. The bench checks that `rst_o` stays low one tick before the period ends and rises on the last tick, which separates a wrong table entry from an off-by-one error in the counter. Kicks and select rewrites are placed mid-period, on the final tick and inside a pulse, to show whether a restart happens, whether it wins over a tick, and whether it is ignored during a pulse. Low-supply episodes are placed during counting and during a pulse, which separates the immediate reset path from the cancelled watchdog state. A clear arriving together with a timeout shows which of the two wins in the flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [2:0] SEL_OFF = 3'b111;
  localparam int unsigned MAX_MS = 60000;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_WDT  = 2'b01,
    CAUSE_LV   = 2'b10
  } cause_e;

  function automatic int unsigned code_ms(input int unsigned code);
    case (code)
      0: return 150;
      1: return 450;
      2: return 1000;
      3: return 5000;
      4: return 10000;
      5: return 20000;
      6: return 60000;
      default: return 0;
    endcase
  endfunction

  // scaled period in ticks, floor of 1 for active codes
  function automatic int unsigned code_ticks(input int unsigned code,
                                             input int unsigned tpm,
                                             input int unsigned div);
    int unsigned t;
    t = code_ms(code) * tpm / div;
    if (code_ms(code) != 0 && t == 0) t = 1;
    return t;
  endfunction

endpackage

// File: rtl/wdt_period_lut.sv
module wdt_period_lut #(
  parameter int unsigned TICKS_PER_MS = 1,
  parameter int unsigned TB_DIV       = 1,
  parameter int unsigned CNT_W        = 16
) (
  input  logic [2:0]       sel_i,
  output logic [CNT_W-1:0] period_o,
  output logic             off_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] tab [8];

  for (genvar g = 0; g < 8; g++) begin : g_tab
    assign tab[g] = CNT_W'(code_ticks(g, TICKS_PER_MS, TB_DIV));
  end

  assign period_o = tab[sel_i];
  assign off_o    = (sel_i == SEL_OFF);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PULSE_TICKS = 100,
  localparam int unsigned PW         = $clog2(PULSE_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic             off_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             pulse_o,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pcnt_q;
  logic             pulse_q;
  logic             last_tick;
  logic             pulse_done;

  assign last_tick  = (cnt_q == period_i - CNT_W'(1));
  assign pulse_done = tick_i && (pcnt_q == PW'(PULSE_TICKS - 1));
  assign fire_o     = !hold_i && !pulse_q && !off_i && !restart_i &&
                      tick_i && last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      if (pulse_done) begin
        pulse_q <= 1'b0;
        pcnt_q  <= '0;
        cnt_q   <= '0;
      end else if (tick_i) begin
        pcnt_q <= pcnt_q + PW'(1);
      end
    end else if (off_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (last_tick) begin
        pulse_q <= 1'b1;
        pcnt_q  <= '0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pulse_o = pulse_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/wdt_cause_flag.sv
module wdt_cause_flag (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wdt_evt_i,
  input  logic       lv_evt_i,
  input  logic       clr_i,
  output logic [1:0] cause_o
);
  import wdt_pkg::*;

  cause_e cause_q;

  // events win over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cause_q <= CAUSE_NONE;
    else if (lv_evt_i)  cause_q <= CAUSE_LV;
    else if (wdt_evt_i) cause_q <= CAUSE_WDT;
    else if (clr_i)     cause_q <= CAUSE_NONE;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int unsigned TICKS_PER_MS = 1,
  parameter int unsigned TB_DIV       = 1,
  parameter int unsigned PULSE_TICKS  = 100,
  parameter logic [2:0]  SEL_RST      = 3'b000,
  localparam int unsigned CNT_W       = $clog2(wdt_pkg::MAX_MS * TICKS_PER_MS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       sel_wr_i,
  input  logic [2:0] sel_i,
  input  logic       vlow_i,
  input  logic       flag_clr_i,
  output logic       rst_o,
  output logic       mem_block_o,
  output logic [1:0] cause_o
);
  logic [2:0]       sel_q;
  logic             vlow_q;
  logic             lv_evt;
  logic [CNT_W-1:0] period;
  logic             off;
  logic             wdt_pulse;
  logic             wdt_fire;
  logic [CNT_W-1:0] wdt_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_RST;
      vlow_q <= 1'b0;
    end else begin
      if (sel_wr_i) sel_q <= sel_i;
      vlow_q <= vlow_i;
    end
  end

  assign lv_evt = vlow_i && !vlow_q;

  wdt_period_lut #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .TB_DIV      (TB_DIV),
    .CNT_W       (CNT_W)
  ) u_lut (
    .sel_i   (sel_q),
    .period_o(period),
    .off_o   (off)
  );

  wdt_timer #(
    .CNT_W      (CNT_W),
    .PULSE_TICKS(PULSE_TICKS)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .restart_i(kick_i || sel_wr_i),
    .hold_i   (vlow_i),
    .off_i    (off),
    .period_i (period),
    .pulse_o  (wdt_pulse),
    .fire_o   (wdt_fire),
    .cnt_o    (wdt_cnt)
  );

  wdt_cause_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdt_evt_i(wdt_fire),
    .lv_evt_i (lv_evt),
    .clr_i    (flag_clr_i),
    .cause_o  (cause_o)
  );

  // low-supply path is combinational so reset holds with no clock delay
  assign rst_o       = wdt_pulse || vlow_i;
  assign mem_block_o = vlow_i;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             kick_i,
  input logic             vlow_i,
  input logic             flag_clr_i,
  input logic             rst_o,
  input logic             mem_block_o,
  input logic [1:0]       cause_o,
  input logic [2:0]       sel_q_i,
  input logic             pulse_i,
  input logic [CNT_W-1:0] cnt_i
);
  // R6
  a_r6_low_forces_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlow_i |-> rst_o);
  // R7
  a_r7_block_tracks_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_block_o == vlow_i);
  // R2
  a_r2_off_never_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q_i == 3'b111 && !pulse_i) |=> !pulse_i);
  // R3
  a_r3_kick_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && !pulse_i) |=> cnt_i == '0);
  // R5
  a_r5_pulse_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_i) |-> cnt_i == '0);
  // R8
  a_r8_wdt_sets_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> cause_o == 2'b01);
  a_r8_lv_sets_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vlow_i) |=> cause_o == 2'b10);
  // R9
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != 2'b00 && !flag_clr_i) |=> cause_o != 2'b00);
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .kick_i     (kick_i),
  .vlow_i     (vlow_i),
  .flag_clr_i (flag_clr_i),
  .rst_o      (rst_o),
  .mem_block_o(mem_block_o),
  .cause_o    (cause_o),
  .sel_q_i    (sel_q),
  .pulse_i    (wdt_pulse),
  .cnt_i      (wdt_cnt)
);

// File: tb/wdt_supervisor_bench.sv
`timescale 1ns/1ps
module wdt_supervisor_bench;
  localparam int DIV   = 50;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, kick_i = 0, sel_wr_i = 0, vlow_i = 0, flag_clr_i = 0;
  logic [2:0] sel_i = '0;
  logic rst_o, mem_block_o;
  logic [1:0] cause_o;

  always #2.5 clk = ~clk;

  wdt_supervisor #(.TICKS_PER_MS(1), .TB_DIV(DIV), .PULSE_TICKS(PULSE)) u_wdt_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .kick_i(kick_i),
    .sel_wr_i(sel_wr_i), .sel_i(sel_i), .vlow_i(vlow_i), .flag_clr_i(flag_clr_i),
    .rst_o(rst_o), .mem_block_o(mem_block_o), .cause_o(cause_o)
  );

  int ms_tab[7] = '{150, 450, 1000, 5000, 10000, 20000, 60000};
  function automatic int per(input int s);
    int p;
    p = ms_tab[s] / DIV;
    return (p < 1) ? 1 : p;
  endfunction

  typedef struct {
    string      req;
    logic       r;
    logic       b;
    logic [1:0] c;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rst_o !== e.r || mem_block_o !== e.b || cause_o !== e.c) begin
        errors++;
        $display("FAIL %s: rst=%b blk=%b cause=%b expected rst=%b blk=%b cause=%b",
                 e.req, rst_o, mem_block_o, cause_o, e.r, e.b, e.c);
      end
    end
  end

  task automatic cyc(input logic t, input logic k, input logic w,
                     input logic [2:0] s, input logic c);
    tick_i = t; kick_i = k; sel_wr_i = w; sel_i = s; flag_clr_i = c;
    @(posedge clk); #1;
    tick_i = 0; kick_i = 0; sel_wr_i = 0; flag_clr_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, sel_i, 0);
  endtask

  task automatic chk(input string r, input logic er, input logic eb, input logic [1:0] ec);
    exp_t e;
    e.req = r; e.r = er; e.b = eb; e.c = ec;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic clear_flag();
    cyc(0, 0, 0, sel_i, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 in reset", 0, 0, 2'b00);
    @(negedge clk); rst_ni = 1; #1;
    chk("R10 after reset", 0, 0, 2'b00);

    // R10: default select is code 0
    ticks(per(0) - 1);
    chk("R10 default sel pre", 0, 0, 2'b00);
    ticks(1);
    chk("R10 default sel fires", 1, 0, 2'b01);
    ticks(PULSE);
    clear_flag();

    // R1 / R5 / R9: every active code
    for (int s = 0; s < 7; s++) begin
      cyc(0, 0, 1, 3'(s), 0);
      ticks(per(s) - 1);
      chk("R1 one tick short", 0, 0, 2'b00);
      ticks(1);
      chk("R1 timeout", 1, 0, 2'b01);
      ticks(PULSE - 1);
      chk("R5 pulse held", 1, 0, 2'b01);
      ticks(1);
      chk("R9 flag kept after pulse", 0, 0, 2'b01);
      clear_flag();
      chk("R9 cleared", 0, 0, 2'b00);
    end

    // R5: count restarts after pulse
    cyc(0, 0, 1, 3'd0, 0);
    ticks(per(0) + PULSE + per(0) - 1);
    chk("R5 restart short", 0, 0, 2'b01);
    ticks(1);
    chk("R5 restart fires", 1, 0, 2'b01);
    ticks(PULSE);
    clear_flag();

    // R3: kick mid period
    cyc(0, 0, 1, 3'd0, 0);
    ticks(2);
    cyc(0, 1, 0, 3'd0, 0);
    ticks(per(0) - 1);
    chk("R3 kick restarts", 0, 0, 2'b00);
    ticks(1);
    chk("R3 fires after kick", 1, 0, 2'b01);
    // R3: kicks ignored inside pulse
    cyc(1, 1, 0, 3'd0, 0);
    cyc(1, 1, 0, 3'd0, 0);
    ticks(PULSE - 3);
    chk("R3 kick ignored in pulse", 1, 0, 2'b01);
    ticks(1);
    chk("R3 pulse length kept", 0, 0, 2'b01);
    clear_flag();

    // R3: kick beats tick on final tick
    cyc(0, 0, 1, 3'd0, 0);
    ticks(per(0) - 1);
    cyc(1, 1, 0, 3'd0, 0);
    chk("R3 kick wins over tick", 0, 0, 2'b00);
    ticks(per(0) - 1);
    chk("R3 after kick short", 0, 0, 2'b00);
    ticks(1);
    chk("R3 after kick fires", 1, 0, 2'b01);
    ticks(PULSE);
    clear_flag();

    // R4: rewrite of same select restarts
    cyc(0, 0, 1, 3'd1, 0);
    ticks(5);
    cyc(0, 0, 1, 3'd1, 0);
    ticks(per(1) - 1);
    chk("R4 rewrite restarts", 0, 0, 2'b00);
    ticks(1);
    chk("R4 fires after rewrite", 1, 0, 2'b01);
    ticks(PULSE);
    clear_flag();

    // R2: off code
    cyc(0, 0, 1, 3'd7, 0);
    ticks(2000);
    chk("R2 off never fires", 0, 0, 2'b00);

    // R9: clear together with timeout
    cyc(0, 0, 1, 3'd0, 0);
    ticks(per(0) - 1);
    cyc(1, 0, 0, 3'd0, 1);
    chk("R9 event beats clear", 1, 0, 2'b01);
    ticks(PULSE);
    clear_flag();

    // R6 / R7 / R8: low supply
    vlow_i = 1;
    cyc(0, 0, 0, 3'd0, 0);
    chk("R6 low forces reset", 1, 1, 2'b10);
    ticks(10);
    chk("R6 no watchdog while low", 1, 1, 2'b10);
    vlow_i = 0;
    cyc(0, 0, 0, 3'd0, 0);
    chk("R7 block released", 0, 0, 2'b10);
    ticks(per(0) - 1);
    chk("R6 count held at zero", 0, 0, 2'b10);
    ticks(1);
    chk("R8 watchdog overwrites", 1, 0, 2'b01);
    vlow_i = 1;
    cyc(0, 0, 0, 3'd0, 0);
    chk("R8 low overwrites", 1, 1, 2'b10);
    vlow_i = 0;
    cyc(0, 0, 0, 3'd0, 0);
    chk("R6 pulse cancelled", 0, 0, 2'b10);
    clear_flag();
    chk("R9 final clear", 0, 0, 2'b00);

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule